// File: doc/BRIEF.md
# PAL-Style Video Timing Generator

The block produces the raster timing for a 625/50-style composite display from a 16 MHz pixel clock, where one cycle is 62.5 ns. A column counter steps through the 1024 cycles (64 µs) of a scanline, and a line counter steps through the 312 lines of a field. From these two counts the block produces a line-sync pulse and a composite sync that also covers the 2.5-line field-sync interval. It also produces a display-enable window and the current pixel column and picture row. A downstream pixel and memory-fetch engine uses these to place its data.

The active window opens at cycle 256 of a line. Because 256 is a multiple of 8, fetch phases that repeat every 8 cycles stay locked to pixel output. The window is 640 cycles wide and covers picture lines 28 to 283. All outputs come from registers. Each output describes the raster position that the counters hold in the same cycle, so the window and the coordinates change together on one clock edge. Every count and limit is a parameter.

Top module: `pal_video_timing`

## Requirements
- R1: One scanline lasts LINE_CYC cycles (default 1024). The line-sync pattern repeats with exactly that period.
- R2: `hsync_o` is high for line cycles 0 to HS_CYC-1 (default 0..63) and low for the rest of the line.
- R3: A field contains LINES scanlines (default 312). After the last line, the raster returns to line 0 and the whole pattern repeats.
- R4: `csync_no` (active low) is held low for the first VS_CYC cycles of every field (default 2560, ending halfway through line 2).
- R5: Outside the field-sync interval, `csync_no` is the inverse of `hsync_o`.
- R6: `de_o` is high exactly when the line cycle is in [ACT_START, ACT_START+ACT_W) (default [256, 896)) and the line is in [PIC_START, PIC_START+PIC_H) (default [28, 284)).
- R7: While `de_o` is high, `col_o` equals the line cycle minus ACT_START and `row_o` equals the line minus PIC_START. While `de_o` is low, both are 0. They change on the same edge as `de_o`.
- R8: `de_o` rises exactly ACT_START cycles after `hsync_o` rises, and that offset is a multiple of 8.
- R9: Asserting `rst_ni` low clears the raster position at once. While reset is held, and in the first cycle after it is released, the outputs show line 0, cycle 0: `hsync_o`=1, `csync_no`=0, `de_o`=0, `col_o`=0, `row_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock, 16 MHz |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_o | output | 1 | Line sync, active high |
| csync_no | output | 1 | Composite sync including field sync, active low |
| de_o | output | 1 | Display-enable window |
| col_o | output | COL_W | Pixel column inside the window, else 0 |
| row_o | output | ROW_W | Picture row inside the window, else 0 |

## Verification
The default-size generator runs free for about a hundred lines. This run separates the line-sync width, the half-line end of field sync and the first picture line from nearby off-by-one variants. A second instance, shrunk through its parameters, runs through many whole fields, so the line wrap and the field wrap are exercised many times. Reset pulses of random length, applied at random raster positions, show whether reset returns the raster to line 0, cycle 0 from any state. A bench model checks every output in every cycle, and an edge-to-edge count checks where the window opens relative to line sync.

// File: rtl/pvt_pkg.sv
package pvt_pkg;
  typedef struct packed {
    logic hs;
    logic vs;
    logic de;
  } pvt_flags_t;
endpackage

// File: rtl/pvt_hcount.sv
module pvt_hcount #(
  parameter int LINE_CYC = 1024,
  localparam int HW = $clog2(LINE_CYC)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [HW-1:0] cnt_o,
  output logic [HW-1:0] nxt_o,
  output logic          eol_o
);
  logic [HW-1:0] cnt_q;

  assign eol_o = (cnt_q == HW'(LINE_CYC - 1));
  assign nxt_o = eol_o ? '0 : cnt_q + 1'b1;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= nxt_o;
  end

  AST_H_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) < LINE_CYC); // R1
endmodule

// File: rtl/pvt_vcount.sv
module pvt_vcount #(
  parameter int LINES = 312,
  localparam int VW = $clog2(LINES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          eol_i,
  output logic [VW-1:0] cnt_o,
  output logic [VW-1:0] nxt_o
);
  logic [VW-1:0] cnt_q;
  logic          last;

  assign last  = (cnt_q == VW'(LINES - 1));
  assign nxt_o = !eol_i ? cnt_q : (last ? '0 : cnt_q + 1'b1);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= nxt_o;
  end

  AST_V_STEP_ON_EOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cnt_q) |-> $past(eol_i)); // R3
  AST_V_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) < LINES); // R3
endmodule

// File: rtl/pvt_decode.sv
module pvt_decode
  import pvt_pkg::*;
#(
  parameter int LINE_CYC  = 1024,
  parameter int HS_CYC    = 64,
  parameter int ACT_START = 256,
  parameter int ACT_W     = 640,
  parameter int LINES     = 312,
  parameter int VS_CYC    = 2560,
  parameter int PIC_START = 28,
  parameter int PIC_H     = 256,
  parameter int COL_W     = 10,
  parameter int ROW_W     = 8,
  localparam int HW = $clog2(LINE_CYC),
  localparam int VW = $clog2(LINES),
  localparam int VS_FULL = VS_CYC / LINE_CYC,
  localparam int VS_REM  = VS_CYC % LINE_CYC
) (
  input  logic [HW-1:0]    h_i,
  input  logic [VW-1:0]    v_i,
  output pvt_flags_t       flags_o,
  output logic [COL_W-1:0] col_o,
  output logic [ROW_W-1:0] row_o
);
  int  h, v;
  logic in_x, in_y;

  always_comb begin
    h = int'(h_i);
    v = int'(v_i);
    in_x = (h >= ACT_START) && (h < ACT_START + ACT_W);
    in_y = (v >= PIC_START) && (v < PIC_START + PIC_H);
    flags_o.hs = (h < HS_CYC);
    // field sync spans whole lines then a partial line
    flags_o.vs = (v < VS_FULL) || ((v == VS_FULL) && (h < VS_REM));
    flags_o.de = in_x && in_y;
    col_o = flags_o.de ? COL_W'(h - ACT_START) : '0;
    row_o = flags_o.de ? ROW_W'(v - PIC_START) : '0;
  end
endmodule

// File: rtl/pal_video_timing.sv
module pal_video_timing
  import pvt_pkg::*;
#(
  parameter int LINE_CYC  = 1024,
  parameter int HS_CYC    = 64,
  parameter int ACT_START = 256,
  parameter int ACT_W     = 640,
  parameter int LINES     = 312,
  parameter int VS_CYC    = 2560,
  parameter int PIC_START = 28,
  parameter int PIC_H     = 256,
  parameter int COL_W     = $clog2(ACT_W),
  parameter int ROW_W     = $clog2(PIC_H)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             hsync_o,
  output logic             csync_no,
  output logic             de_o,
  output logic [COL_W-1:0] col_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int HW = $clog2(LINE_CYC);
  localparam int VW = $clog2(LINES);

  logic [HW-1:0]    h_q, h_nxt;
  logic [VW-1:0]    v_q, v_nxt;
  logic             eol;
  pvt_flags_t       flags_nxt;
  logic [COL_W-1:0] col_nxt;
  logic [ROW_W-1:0] row_nxt;

  pvt_hcount #(.LINE_CYC(LINE_CYC)) u_hcount (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_o(h_q), .nxt_o(h_nxt), .eol_o(eol)
  );

  pvt_vcount #(.LINES(LINES)) u_vcount (
    .clk_i(clk_i), .rst_ni(rst_ni), .eol_i(eol), .cnt_o(v_q), .nxt_o(v_nxt)
  );

  // decode the next position so registered outputs line up with the counters
  pvt_decode #(
    .LINE_CYC(LINE_CYC), .HS_CYC(HS_CYC), .ACT_START(ACT_START), .ACT_W(ACT_W),
    .LINES(LINES), .VS_CYC(VS_CYC), .PIC_START(PIC_START), .PIC_H(PIC_H),
    .COL_W(COL_W), .ROW_W(ROW_W)
  ) u_decode (
    .h_i(h_nxt), .v_i(v_nxt), .flags_o(flags_nxt), .col_o(col_nxt), .row_o(row_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hsync_o  <= 1'b1;
      csync_no <= 1'b0;
      de_o     <= 1'b0;
      col_o    <= '0;
      row_o    <= '0;
    end else begin
      hsync_o  <= flags_nxt.hs;
      csync_no <= !(flags_nxt.vs || flags_nxt.hs);
      de_o     <= flags_nxt.de;
      col_o    <= col_nxt;
      row_o    <= row_nxt;
    end
  end

  AST_HS_AT_LINE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_q == '0) |-> hsync_o); // R2
  AST_CSYNC_LINE0_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_q == '0) |-> !csync_no); // R4
  AST_CSYNC_FOLLOWS_HS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(v_q) > VS_CYC / LINE_CYC) |-> (csync_no == !hsync_o)); // R5
  AST_DE_COORD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_o |-> (col_o == '0 && row_o == '0)); // R7
  AST_DE_RISE_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(de_o) |-> (col_o == '0 && h_q[2:0] == 3'd0)); // R8
endmodule

// File: tb/pal_video_timing_tb.sv
`timescale 1ns/1ps
module pal_video_timing_tb_top;
  localparam int CLK_PERIOD = 62;
  localparam int MAX_CYC    = 200000;

  // small instance parameters
  localparam int S_LC = 128, S_HS = 8, S_AS = 32, S_AW = 80, S_NL = 40;
  localparam int S_VS = 320, S_PS = 6, S_PH = 24;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  logic       d_hs, d_csn, d_de;
  logic [9:0] d_col;
  logic [7:0] d_row;
  logic       s_hs, s_csn, s_de;
  logic [6:0] s_col;
  logic [4:0] s_row;

  pal_video_timing dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .hsync_o(d_hs), .csync_no(d_csn),
    .de_o(d_de), .col_o(d_col), .row_o(d_row)
  );

  pal_video_timing #(
    .LINE_CYC(S_LC), .HS_CYC(S_HS), .ACT_START(S_AS), .ACT_W(S_AW),
    .LINES(S_NL), .VS_CYC(S_VS), .PIC_START(S_PS), .PIC_H(S_PH)
  ) dut_small_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .hsync_o(s_hs), .csync_no(s_csn),
    .de_o(s_de), .col_o(s_col), .row_o(s_row)
  );

  int checks = 0, fails = 0;
  int pos = 0, cyc = 0;
  bit done = 1'b0;
  bit d_hs_p, d_de_p, s_hs_p, s_de_p;
  int d_hs_rise, s_hs_rise;

  task automatic cmp(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s pos=%0d actual=%0d expected=%0d", tag, what, pos, act, exp);
    end
  endtask

  task automatic check_one(string name, int p, int lc, int hsc, int as, int aw,
                           int nl, int vsc, int ps, int ph,
                           bit hs, bit csn, bit de, int col, int row, bit rst_tag);
    int f, h, v;
    bit ehs, evs, ede;
    string t_hs, t_cs, t_de, t_cr;
    f = p % (lc * nl);
    h = f % lc;
    v = f / lc;
    ehs = h < hsc;
    evs = f < vsc;
    ede = (h >= as) && (h < as + aw) && (v >= ps) && (v < ps + ph);
    t_hs = rst_tag ? "R9" : (p >= lc * nl ? "R3" : (p >= lc ? "R1" : "R2"));
    t_cs = rst_tag ? "R9" : (p >= lc * nl ? "R3" : (evs ? "R4" : "R5"));
    t_de = rst_tag ? "R9" : (p >= lc * nl ? "R3" : "R6");
    t_cr = rst_tag ? "R9" : (p >= lc * nl ? "R3" : "R7");
    cmp(t_hs, {name, " hsync"}, int'(hs), int'(ehs));
    cmp(t_cs, {name, " csync_n"}, int'(csn), int'(!(evs || ehs)));
    cmp(t_de, {name, " de"}, int'(de), int'(ede));
    cmp(t_cr, {name, " col"}, col, ede ? h - as : 0);
    cmp(t_cr, {name, " row"}, row, ede ? v - ps : 0);
  endtask

  task automatic check_all(bit rst_tag);
    check_one("big", pos, 1024, 64, 256, 640, 312, 2560, 28, 256,
              d_hs, d_csn, d_de, int'(d_col), int'(d_row), rst_tag);
    check_one("small", pos, S_LC, S_HS, S_AS, S_AW, S_NL, S_VS, S_PS, S_PH,
              s_hs, s_csn, s_de, int'(s_col), int'(s_row), rst_tag);
  endtask

  // R8: window opening measured from the line-sync rising edge
  task automatic track_edges();
    if (d_hs && !d_hs_p) d_hs_rise = cyc;
    if (s_hs && !s_hs_p) s_hs_rise = cyc;
    if (d_de && !d_de_p) begin
      cmp("R8", "big de offset", cyc - d_hs_rise, 256);
      cmp("R8", "big de offset mod 8", (cyc - d_hs_rise) % 8, 0);
    end
    if (s_de && !s_de_p) begin
      cmp("R8", "small de offset", cyc - s_hs_rise, S_AS);
      cmp("R8", "small de offset mod 8", (cyc - s_hs_rise) % 8, 0);
    end
    d_hs_p = d_hs; d_de_p = d_de; s_hs_p = s_hs; s_de_p = s_de;
  endtask

  task automatic restart_tracking();
    d_hs_p = 1'b1; s_hs_p = 1'b1; d_de_p = 1'b0; s_de_p = 1'b0;
    d_hs_rise = cyc; s_hs_rise = cyc;
  endtask

  task automatic run_cycles(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      pos++;
      cyc++;
      @(negedge clk_i);
      check_all(1'b0);
      track_edges();
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    void'($urandom(32'h1f2e3d4c));
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check_all(1'b1); // R9 held reset
    rst_ni = 1'b1;
    pos = 0;
    #1 check_all(1'b1); // R9 first cycle after release
    restart_tracking();
    run_cycles(100000);
    for (int k = 0; k < 3; k++) begin
      // R9: asynchronous reset at a random raster position
      #(CLK_PERIOD/4) rst_ni = 1'b0;
      pos = 0;
      #1 check_all(1'b1);
      repeat (1 + ($urandom % 4)) @(negedge clk_i);
      check_all(1'b1);
      rst_ni = 1'b1;
      #1 check_all(1'b1);
      restart_tracking();
      run_cycles(6000 + ($urandom % 6000));
    end
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * MAX_CYC);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired pos=%0d", pos);
      summary();
      $finish;
    end
  end
endmodule